// File: doc/BRIEF.md
# Beam Destination Arbiter

The arbiter chooses where each batch cycle bound for the collider is sent. It can send the batch to transfer line 1 or transfer line 2, to the beam dump at the end of either line, or to the internal dump. It can also kill the beam at the source while the magnet cycle still runs, or place the beam in the spare state. The choice is made once per batch cycle, at a forewarning strobe. It depends on who holds mastership, whether a fill request is active, the user request, the line dump requests, the dump-in-place status, the per-line interlock inhibits and an abnormal-interlock flag. The chosen destination is then held until the next strobe.

The block also holds the mastership flag. The sequencer can take or give up mastership only while the user request is absent. Taking mastership also needs the allow bit. A denied request raises a one-cycle error pulse.

A fill request carries a ring, a bucket and a batch count. The block checks it and keeps it as pending. At the next supercycle start the pending request becomes the active one. Each batch sent down a transfer line decrements the active count. When the count reaches zero the request is used up, and the next cycle falls back to the default for a master with no request.

Top module: `beam_dest_arbiter`

## Requirements
- R1: A synchronous active-high reset sets `dest` to spare (code 0) and clears `is_master`, `fill_pending`, `batches_left`, `master_err` and `fill_err`.
- R2: `dest` changes only on the clock edge that samples `fwarn` high, and is visible one cycle later. Without `fwarn` it holds its value whatever the other inputs do.
- R3: If `abnormal` is high at the strobe, the destination is spare (0). This overrides every other rule.
- R4: Otherwise, if `user_req` is low at the strobe, the destination is spare (0).
- R5: When master, with an active request and no inhibit on its line, ring 0 sends the batch to line 1 (code 1) and ring 1 sends it to line 2 (code 2). The inhibit on the other line has no effect. An inhibit on the request's own line gives spare (0) and consumes no batch.
- R6: When master with no active request (`batches_left` = 0), the destination is beam killed (code 6).
- R7: When not master, a dump request on line 1 takes priority over one on line 2. It gives dump 1 (code 3) or dump 2 (code 4) if `dump_in_place` is high, and spare (0) if not. With no dump request the destination is the internal dump (code 5).
- R8: Each strobe that selects line 1 or line 2 decrements `batches_left` by one. At zero the request is finished, and R6 applies at the next strobe.
- R9: A fill write is stored as pending only if its bucket is below 35640 and its batch count is 1 to 4. A new valid write overwrites an older pending request. An invalid write gives a one-cycle `fill_err` pulse and leaves the pending state unchanged.
- R10: `sc_start` with a request pending loads `batches_left`, `act_ring` and `act_bucket` from it and clears `fill_pending`. If a strobe arrives in the same cycle, its decision uses the old state, and the load takes precedence over its decrement. `sc_start` with nothing pending changes nothing.
- R11: `master_req` grants mastership only when `allow` is high and `user_req` is low. Otherwise it gives a one-cycle `master_err` pulse. While `user_req` is high, mastership never changes.
- R12: `master_rel` drops mastership when `user_req` is low. If `user_req` is high it raises `master_err` and mastership is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwarn | input | 1 | Forewarning strobe; latches the destination |
| sc_start | input | 1 | Supercycle start; activates the pending fill request |
| abnormal | input | 1 | Abnormal interlock present |
| user_req | input | 1 | User request present |
| master_req | input | 1 | Pulse: sequencer asks for mastership |
| master_rel | input | 1 | Pulse: sequencer gives up mastership |
| allow | input | 1 | Mastership handover allowed |
| dump1_req | input | 1 | Dump on line 1 requested |
| dump2_req | input | 1 | Dump on line 2 requested |
| dump_in_place | input | 1 | Line dumps reported in place |
| inhib1 | input | 1 | Interlock inhibit on line 1 |
| inhib2 | input | 1 | Interlock inhibit on line 2 |
| fill_wr | input | 1 | Pulse: write a fill request |
| fill_ring | input | 1 | Fill ring (0 = line 1, 1 = line 2) |
| fill_bucket | input | 16 | Fill bucket number |
| fill_batches | input | 3 | Fill batch count |
| dest | output | 3 | Latched destination code |
| is_master | output | 1 | Sequencer holds mastership |
| master_err | output | 1 | One-cycle mastership refusal pulse |
| fill_pending | output | 1 | A fill request is pending |
| fill_err | output | 1 | One-cycle fill rejection pulse |
| batches_left | output | 3 | Batches remaining in the active request |
| act_ring | output | 1 | Ring of the active request |
| act_bucket | output | 16 | Bucket of the active request |

## Verification
Most internal state is visible on its own port, so faults show up quickly. A wrong mastership flag or batch count appears on `is_master` or `batches_left` one cycle after the input that set it. A fault in the destination rules stays hidden until the next forewarning strobe, and then shows on `dest` one cycle after that strobe. A stale pending request shows only at the next supercycle start, when `batches_left`, `act_ring` and `act_bucket` load the wrong values. The bench therefore follows every strobe and every supercycle start with a comparison against its model.

// File: rtl/bda_pkg.sv
package bda_pkg;
  typedef enum logic [2:0] {
    DST_SPARE    = 3'd0,
    DST_LINE1    = 3'd1,
    DST_LINE2    = 3'd2,
    DST_DUMP1    = 3'd3,
    DST_DUMP2    = 3'd4,
    DST_INTERNAL = 3'd5,
    DST_KILL     = 3'd6
  } dest_e;
endpackage

// File: rtl/bda_master_ctl.sv
module bda_master_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic rel,
  input  logic allow,
  input  logic user_req,
  output logic is_master,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      is_master <= 1'b0;
      err       <= 1'b0;
    end else begin
      err <= 1'b0;
      if (req) begin
        if (allow && !user_req) is_master <= 1'b1;
        else                    err       <= 1'b1;
      end else if (rel) begin
        if (!user_req) is_master <= 1'b0;
        else           err       <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bda_fill_req.sv
module bda_fill_req #(
  parameter int BUCKETS   = 35640,
  parameter int MAX_BATCH = 4,
  parameter int BKT_W     = $clog2(BUCKETS),
  parameter int BAT_W     = $clog2(MAX_BATCH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             ring,
  input  logic [BKT_W-1:0] bucket,
  input  logic [BAT_W-1:0] batches,
  input  logic             sc_start,
  input  logic             take,
  output logic             pending,
  output logic             err,
  output logic [BAT_W-1:0] left,
  output logic             act_ring,
  output logic [BKT_W-1:0] act_bucket
);
  logic             p_ring;
  logic [BKT_W-1:0] p_bucket;
  logic [BAT_W-1:0] p_bat;
  logic             wr_ok;

  assign wr_ok = (32'(bucket) < BUCKETS) && (batches != '0) &&
                 (32'(batches) <= MAX_BATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      err        <= 1'b0;
      left       <= '0;
      act_ring   <= 1'b0;
      act_bucket <= '0;
      p_ring     <= 1'b0;
      p_bucket   <= '0;
      p_bat      <= '0;
    end else begin
      err <= wr && !wr_ok;
      if (sc_start && pending) begin
        left       <= p_bat;
        act_ring   <= p_ring;
        act_bucket <= p_bucket;
      end else if (take && left != '0) begin
        left <= left - BAT_W'(1);
      end
      if (wr && wr_ok) begin
        p_ring   <= ring;
        p_bucket <= bucket;
        p_bat    <= batches;
        pending  <= 1'b1;
      end else if (sc_start) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bda_dest_sel.sv
module bda_dest_sel
  import bda_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fwarn,
  input  logic       abnormal,
  input  logic       user_req,
  input  logic       is_master,
  input  logic       has_req,
  input  logic       act_ring,
  input  logic       inhib1,
  input  logic       inhib2,
  input  logic       dump1_req,
  input  logic       dump2_req,
  input  logic       dump_in_place,
  output logic [2:0] dest,
  output logic       take
);
  dest_e nxt;
  logic  line_pick;

  always_comb begin
    nxt       = DST_SPARE;
    line_pick = 1'b0;
    if (abnormal || !user_req) begin
      nxt = DST_SPARE;
    end else if (is_master) begin
      if (!has_req)                  nxt = DST_KILL;
      else if (act_ring && !inhib2)  begin nxt = DST_LINE2; line_pick = 1'b1; end
      else if (!act_ring && !inhib1) begin nxt = DST_LINE1; line_pick = 1'b1; end
      else                           nxt = DST_SPARE;
    end else if (dump1_req) begin
      nxt = dump_in_place ? DST_DUMP1 : DST_SPARE;
    end else if (dump2_req) begin
      nxt = dump_in_place ? DST_DUMP2 : DST_SPARE;
    end else begin
      nxt = DST_INTERNAL;
    end
  end

  assign take = fwarn && line_pick;

  always_ff @(posedge clk) begin
    if (rst)        dest <= DST_SPARE;
    else if (fwarn) dest <= nxt;
  end
endmodule

// File: rtl/beam_dest_arbiter.sv
module beam_dest_arbiter #(
  parameter int BUCKETS   = 35640,
  parameter int MAX_BATCH = 4,
  parameter int BKT_W     = $clog2(BUCKETS),
  parameter int BAT_W     = $clog2(MAX_BATCH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwarn,
  input  logic             sc_start,
  input  logic             abnormal,
  input  logic             user_req,
  input  logic             master_req,
  input  logic             master_rel,
  input  logic             allow,
  input  logic             dump1_req,
  input  logic             dump2_req,
  input  logic             dump_in_place,
  input  logic             inhib1,
  input  logic             inhib2,
  input  logic             fill_wr,
  input  logic             fill_ring,
  input  logic [BKT_W-1:0] fill_bucket,
  input  logic [BAT_W-1:0] fill_batches,
  output logic [2:0]       dest,
  output logic             is_master,
  output logic             master_err,
  output logic             fill_pending,
  output logic             fill_err,
  output logic [BAT_W-1:0] batches_left,
  output logic             act_ring,
  output logic [BKT_W-1:0] act_bucket
);
  logic take;

  bda_master_ctl u_master (
    .clk(clk), .rst(rst), .req(master_req), .rel(master_rel),
    .allow(allow), .user_req(user_req), .is_master(is_master), .err(master_err)
  );

  bda_fill_req #(
    .BUCKETS(BUCKETS), .MAX_BATCH(MAX_BATCH), .BKT_W(BKT_W), .BAT_W(BAT_W)
  ) u_fill (
    .clk(clk), .rst(rst), .wr(fill_wr), .ring(fill_ring), .bucket(fill_bucket),
    .batches(fill_batches), .sc_start(sc_start), .take(take),
    .pending(fill_pending), .err(fill_err), .left(batches_left),
    .act_ring(act_ring), .act_bucket(act_bucket)
  );

  bda_dest_sel u_sel (
    .clk(clk), .rst(rst), .fwarn(fwarn), .abnormal(abnormal),
    .user_req(user_req), .is_master(is_master), .has_req(batches_left != '0),
    .act_ring(act_ring), .inhib1(inhib1), .inhib2(inhib2),
    .dump1_req(dump1_req), .dump2_req(dump2_req),
    .dump_in_place(dump_in_place), .dest(dest), .take(take)
  );
endmodule

// File: rtl/bda_checker.sv
module bda_checker #(
  parameter int BUCKETS   = 35640,
  parameter int MAX_BATCH = 4,
  parameter int BKT_W     = $clog2(BUCKETS),
  parameter int BAT_W     = $clog2(MAX_BATCH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             fwarn,
  input logic             sc_start,
  input logic             abnormal,
  input logic             user_req,
  input logic             master_req,
  input logic             allow,
  input logic             fill_wr,
  input logic [BKT_W-1:0] fill_bucket,
  input logic [2:0]       dest,
  input logic             is_master,
  input logic             master_err,
  input logic             fill_pending,
  input logic             fill_err,
  input logic [BAT_W-1:0] batches_left
);
  // R2
  dest_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fwarn |=> $stable(dest));
  // R3
  abnormal_spare_chk: assert property (@(posedge clk) disable iff (rst)
    (fwarn && abnormal) |=> dest == 3'd0);
  // R5
  line_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
    (fwarn && !is_master) |=> (dest != 3'd1 && dest != 3'd2));
  // R6
  idle_master_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (fwarn && !abnormal && user_req && is_master && batches_left == '0) |=> dest == 3'd6);
  // R8
  batch_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(batches_left) <= MAX_BATCH);
  // R9
  bad_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_wr && !sc_start && 32'(fill_bucket) >= BUCKETS) |=> (fill_err && $stable(fill_pending)));
  // R11
  master_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    user_req |=> $stable(is_master));
  // R11
  master_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (master_req && !allow) |=> (master_err && $stable(is_master)));
endmodule

bind beam_dest_arbiter bda_checker #(
  .BUCKETS(BUCKETS), .MAX_BATCH(MAX_BATCH), .BKT_W(BKT_W), .BAT_W(BAT_W)
) u_chk (
  .clk(clk), .rst(rst), .fwarn(fwarn), .sc_start(sc_start), .abnormal(abnormal),
  .user_req(user_req), .master_req(master_req), .allow(allow), .fill_wr(fill_wr),
  .fill_bucket(fill_bucket), .dest(dest), .is_master(is_master),
  .master_err(master_err), .fill_pending(fill_pending), .fill_err(fill_err),
  .batches_left(batches_left)
);

// File: tb/beam_dest_arbiter_test.sv
module beam_dest_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, fwarn, sc_start, abnormal, user_req, master_req, master_rel, allow;
  logic dump1_req, dump2_req, dump_in_place, inhib1, inhib2, fill_wr, fill_ring;
  logic [15:0] fill_bucket;
  logic [2:0]  fill_batches;
  logic [2:0]  dest;
  logic        is_master, master_err, fill_pending, fill_err, act_ring;
  logic [2:0]  batches_left;
  logic [15:0] act_bucket;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_dest = 0, m_master = 0, m_merr = 0, m_pend = 0, m_ferr = 0;
  int m_left = 0, m_ring = 0, m_bkt = 0, p_ring = 0, p_bkt = 0, p_bat = 0;
  string t_dest = "R1", t_mst = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  beam_dest_arbiter uut (
    .clk(clk), .rst(rst), .fwarn(fwarn), .sc_start(sc_start), .abnormal(abnormal),
    .user_req(user_req), .master_req(master_req), .master_rel(master_rel),
    .allow(allow), .dump1_req(dump1_req), .dump2_req(dump2_req),
    .dump_in_place(dump_in_place), .inhib1(inhib1), .inhib2(inhib2),
    .fill_wr(fill_wr), .fill_ring(fill_ring), .fill_bucket(fill_bucket),
    .fill_batches(fill_batches), .dest(dest), .is_master(is_master),
    .master_err(master_err), .fill_pending(fill_pending), .fill_err(fill_err),
    .batches_left(batches_left), .act_ring(act_ring), .act_bucket(act_bucket)
  );

  always @(posedge clk) begin
    int nd;
    bit tk;
    if (rst) begin
      m_dest = 0; m_master = 0; m_merr = 0; m_pend = 0; m_ferr = 0;
      m_left = 0; m_ring = 0; m_bkt = 0; p_ring = 0; p_bkt = 0; p_bat = 0;
      t_dest = "R1"; t_mst = "R1";
    end else begin
      tk = 0;
      if (fwarn) begin
        if (abnormal) begin nd = 0; t_dest = "R3"; end
        else if (!user_req) begin nd = 0; t_dest = "R4"; end
        else if (m_master != 0) begin
          if (m_left == 0) begin nd = 6; t_dest = "R6"; end
          else if ((m_ring == 1 && inhib2) || (m_ring == 0 && inhib1)) begin nd = 0; t_dest = "R5"; end
          else begin nd = (m_ring == 1) ? 2 : 1; tk = 1; t_dest = "R5"; end
        end else begin
          t_dest = "R7";
          if (dump1_req)      nd = dump_in_place ? 3 : 0;
          else if (dump2_req) nd = dump_in_place ? 4 : 0;
          else                nd = 5;
        end
        m_dest = nd;
      end else t_dest = "R2";
      m_merr = 0;
      if (master_req) begin
        t_mst = "R11";
        if (allow && !user_req) m_master = 1; else m_merr = 1;
      end else if (master_rel) begin
        t_mst = "R12";
        if (!user_req) m_master = 0; else m_merr = 1;
      end
      if (sc_start && m_pend != 0) begin
        m_left = p_bat; m_ring = p_ring; m_bkt = p_bkt;
      end else if (tk && m_left > 0) m_left = m_left - 1;
      m_ferr = 0;
      if (fill_wr) begin
        if (fill_bucket < 35640 && fill_batches >= 1 && fill_batches <= 4) begin
          p_ring = fill_ring; p_bkt = fill_bucket; p_bat = fill_batches; m_pend = 1;
        end else begin
          m_ferr = 1;
          if (sc_start) m_pend = 0;
        end
      end else if (sc_start) m_pend = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    chk({t_dest, " dest"}, dest, m_dest);
    chk({t_mst, " is_master"}, is_master, m_master);
    chk("R11 master_err", master_err, m_merr);
    chk("R9 fill_pending", fill_pending, m_pend);
    chk("R9 fill_err", fill_err, m_ferr);
    chk("R8 batches_left", batches_left, m_left);
    chk("R10 act_ring", act_ring, m_ring);
    chk("R10 act_bucket", act_bucket, m_bkt);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fw();
    fwarn = 1'b1; tick(1); fwarn = 1'b0;
  endtask

  task automatic fill(input logic r, input int b, input int n);
    fill_wr = 1'b1; fill_ring = r; fill_bucket = 16'(b); fill_batches = 3'(n);
    tick(1); fill_wr = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    tick(100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst = 1; fwarn = 0; sc_start = 0; abnormal = 0; user_req = 0; master_req = 0;
    master_rel = 0; allow = 0; dump1_req = 0; dump2_req = 0; dump_in_place = 0;
    inhib1 = 0; inhib2 = 0; fill_wr = 0; fill_ring = 0; fill_bucket = 0; fill_batches = 0;
    tick(3);
    // R1 reset state
    chk("R1 dest", dest, 0); chk("R1 master", is_master, 0);
    chk("R1 pending", fill_pending, 0); chk("R1 left", batches_left, 0);
    rst = 0;
    user_req = 1;
    fw(); chk("R7 internal", dest, 5);
    dump1_req = 1; dump_in_place = 1;
    fw(); chk("R7 dump1", dest, 3);
    dump_in_place = 0;
    fw(); chk("R7 dump not in place", dest, 0);
    dump1_req = 0; dump2_req = 1; dump_in_place = 1;
    fw(); chk("R7 dump2", dest, 4);
    dump1_req = 1;
    fw(); chk("R7 dump1 priority", dest, 3);
    dump1_req = 0; dump2_req = 0;
    abnormal = 1;
    fw(); chk("R3 abnormal", dest, 0);
    abnormal = 0;
    user_req = 0;
    fw(); chk("R4 no user", dest, 0);
    user_req = 1;
    fw(); chk("R7 internal again", dest, 5);
    abnormal = 1; dump1_req = 1; tick(3);
    chk("R2 hold", dest, 5);
    abnormal = 0; dump1_req = 0;
    // mastership
    master_req = 1; tick(1); master_req = 0;
    chk("R11 deny allow", master_err, 1); chk("R11 not master", is_master, 0);
    allow = 1; master_req = 1; tick(1); master_req = 0;
    chk("R11 deny user", master_err, 1); chk("R11 still not", is_master, 0);
    user_req = 0; master_req = 1; tick(1); master_req = 0;
    chk("R11 grant", is_master, 1);
    user_req = 1;
    fw(); chk("R6 kill", dest, 6);
    // fill requests
    fill(1'b1, 35640, 2); chk("R9 bucket limit", fill_err, 1); chk("R9 pend", fill_pending, 0);
    fill(1'b1, 100, 0); chk("R9 zero batch", fill_err, 1);
    fill(1'b1, 100, 5); chk("R9 five batch", fill_err, 1);
    fill(1'b1, 35639, 2); chk("R9 accepted", fill_pending, 1); chk("R9 no err", fill_err, 0);
    sc_start = 1; tick(1); sc_start = 0;
    chk("R10 load", batches_left, 2); chk("R10 bucket", act_bucket, 35639);
    chk("R10 ring", act_ring, 1); chk("R10 pend cleared", fill_pending, 0);
    fw(); chk("R5 line2", dest, 2); chk("R8 count", batches_left, 1);
    inhib2 = 1;
    fw(); chk("R5 inhibited", dest, 0); chk("R5 no count", batches_left, 1);
    inhib2 = 0; inhib1 = 1;
    fw(); chk("R5 other inhibit", dest, 2); chk("R8 zero", batches_left, 0);
    inhib1 = 0;
    fw(); chk("R8 back to kill", dest, 6);
    sc_start = 1; tick(1); sc_start = 0;
    chk("R10 nothing pending", batches_left, 0);
    fill(1'b0, 0, 1);
    sc_start = 1; fwarn = 1; tick(1); sc_start = 0; fwarn = 0;
    chk("R10 same cycle dest", dest, 6); chk("R10 same cycle load", batches_left, 1);
    fw(); chk("R5 line1", dest, 1); chk("R8 done", batches_left, 0);
    user_req = 0;
    fw(); chk("R4 master no user", dest, 0);
    user_req = 1;
    master_rel = 1; tick(1); master_rel = 0;
    chk("R12 refuse", master_err, 1); chk("R12 kept", is_master, 1);
    user_req = 0; master_rel = 1; tick(1); master_rel = 0;
    chk("R12 released", is_master, 0);
    user_req = 1;
    fw(); chk("R7 default after release", dest, 5);
    tick(2);
    report();
  end
endmodule